// File: doc/BRIEF.md
# Flash Block Lock Protection Controller

This block holds the write-protection state of every erase block in a multi-bank NOR flash array and rules on each program or erase request before the array sequencer may start. Each block carries two bits: a lock bit that refuses writes and a lock-down bit that pins the lock bit in place while the hardware write-protect pin is driven low. Lock, unlock and lock-down commands arrive already decoded, each with a binary block index, and they take effect at the clock edge that accepts them.

A request names a target block and carries a digital code for the program-supply level. The code is sampled only in the cycle the request starts. The block answers one cycle later with a one-cycle grant or deny pulse. A refusal caused by a locked block also sets a sticky protection-error flag. A granted operation holds a run flag until the sequencer reports completion, whatever the supply code does afterwards. A registered read port returns the two bits of any one block per cycle. Power-up and the flash reset input both put every block back into the locked state.

Top module: `flp_block_guard`

## Requirements
- R1: After `rst_n` is released, and one cycle after a cycle with `dev_reset` high, every block reads locked=1 and lockdn=0, and `prot_err`, `op_run`, `grant` and `deny` are 0.
- R2: A command with `cmd_valid` high and `cmd_op` = 2'b01 locks block `cmd_blk` and 2'b10 unlocks it (2'b00 does nothing). A request issued in the very next cycle already sees the new state.
- R3: `cmd_op` = 2'b11 sets both the lock and the lock-down bit of the block. The lock-down bit is cleared only by `rst_n` or `dev_reset`.
- R4: While `wp_n` is 0, lock, unlock and lock-down commands addressed to a block whose lock-down bit is set leave both of its bits unchanged.
- R5: While `wp_n` is 1, lock and unlock commands change the lock bit of a locked-down block and leave its lock-down bit set.
- R6: A request (`op_start` high) with `op_run` low, `vpp_lvl` not 0 and the target block unlocked gives a one-cycle `grant` in the following cycle and sets `op_run` from that cycle.
- R7: A request whose `vpp_lvl` equals 0 (below the lockout threshold) is denied whatever the lock state of the block, and it does not set `prot_err`.
- R8: A request with `op_run` low and `vpp_lvl` not 0 to a locked block gives a one-cycle `deny` and sets `prot_err`. `prot_err` stays set until a cycle with `clr_status` high, and a new error in that same cycle keeps it set.
- R9: `op_run` stays high from the grant until a cycle with `op_done` high, regardless of later `vpp_lvl` values. A request arriving while `op_run` is high is denied without touching `prot_err`.
- R10: `rd_locked` and `rd_lockdn` show the two bits of block `rd_blk` one cycle after `rd_blk` is presented.
- R11: Each request outside a `dev_reset` cycle produces exactly one of `grant` and `deny` in the following cycle, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, asynchronous assert, active low |
| dev_reset | input | 1 | Flash reset, synchronous, re-locks all blocks |
| cmd_valid | input | 1 | Lock command strobe |
| cmd_op | input | 2 | 00 none, 01 lock, 10 unlock, 11 lock-down |
| cmd_blk | input | IDX_W | Block addressed by the command |
| wp_n | input | 1 | Write-protect pin, low freezes locked-down blocks |
| op_start | input | 1 | Program or erase request strobe |
| op_blk | input | IDX_W | Block targeted by the request |
| vpp_lvl | input | 2 | Program-supply level code, 0 is below lockout |
| op_done | input | 1 | Running operation has completed |
| clr_status | input | 1 | Clears the protection-error flag |
| rd_blk | input | IDX_W | Block to read back |
| grant | output | 1 | Request accepted, one-cycle pulse |
| deny | output | 1 | Request refused, one-cycle pulse |
| prot_err | output | 1 | Sticky protection-error flag |
| op_run | output | 1 | A granted operation is in progress |
| rd_locked | output | 1 | Lock bit of the block read back |
| rd_lockdn | output | 1 | Lock-down bit of the block read back |

## Verification
The hardest state to reach from the ports is a locked-down block that has been unlocked. It needs a lock-down command, then `wp_n` raised, then an unlock, then `wp_n` lowered again. Only in that state do the freeze rule and the lock bit point in different directions. The bench builds this sequence on purpose and then checks that a lock command is ignored and that a request to the block is still granted. The supply-sampling rule also needs an operation already running, so the bench grants one, drives the supply code to the lockout value and checks that the run flag holds and that a second request is refused as busy.

// File: rtl/flp_pkg.sv
package flp_pkg;
  typedef enum logic [1:0] {
    LK_NONE = 2'b00,
    LK_SET  = 2'b01,
    LK_CLR  = 2'b10,
    LK_DOWN = 2'b11
  } lk_op_e;

  localparam int VPP_W = 2;
endpackage

// File: rtl/flp_lock_cell.sv
module flp_lock_cell
  import flp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   dev_reset,
  input  logic   cmd_hit,
  input  lk_op_e cmd_op,
  input  logic   wp_n,
  output logic   locked,
  output logic   lockdn
);
  logic lk_nxt;
  logic ld_nxt;
  logic upd_en;
  logic frozen;

  assign frozen = lockdn & ~wp_n;
  assign upd_en = dev_reset | cmd_hit;

  always_comb begin
    lk_nxt = locked;
    ld_nxt = lockdn;
    if (dev_reset) begin
      lk_nxt = 1'b1;
      ld_nxt = 1'b0;
    end else if (cmd_hit && !frozen) begin
      case (cmd_op)
        LK_SET:  lk_nxt = 1'b1;
        LK_CLR:  lk_nxt = 1'b0;
        LK_DOWN: begin
          lk_nxt = 1'b1;
          ld_nxt = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b1;
      lockdn <= 1'b0;
    end else if (upd_en) begin
      locked <= lk_nxt;
      lockdn <= ld_nxt;
    end
  end
endmodule

// File: rtl/flp_req_gate.sv
module flp_req_gate
  import flp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_reset,
  input  logic             op_start,
  input  logic             tgt_locked,
  input  logic [VPP_W-1:0] vpp_lvl,
  input  logic             op_done,
  input  logic             clr_status,
  output logic             grant,
  output logic             deny,
  output logic             prot_err,
  output logic             op_run
);
  logic accept;
  logic vpp_ok;
  logic ok;
  logic lock_hit;
  logic g_nxt, d_nxt, e_nxt, r_nxt;

  always_comb begin
    accept   = op_start & ~op_run;
    vpp_ok   = (vpp_lvl != '0);
    ok       = accept & vpp_ok & ~tgt_locked;
    lock_hit = accept & vpp_ok & tgt_locked;
    g_nxt    = ~dev_reset & ok;
    d_nxt    = ~dev_reset & op_start & ~ok;
    if (dev_reset)       e_nxt = 1'b0;
    else if (lock_hit)   e_nxt = 1'b1;
    else if (clr_status) e_nxt = 1'b0;
    else                 e_nxt = prot_err;
    if (dev_reset)       r_nxt = 1'b0;
    else if (ok)         r_nxt = 1'b1;
    else if (op_done)    r_nxt = 1'b0;
    else                 r_nxt = op_run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant    <= 1'b0;
      deny     <= 1'b0;
      prot_err <= 1'b0;
      op_run   <= 1'b0;
    end else begin
      grant    <= g_nxt;
      deny     <= d_nxt;
      prot_err <= e_nxt;
      op_run   <= r_nxt;
    end
  end
endmodule

// File: rtl/flp_block_guard.sv
module flp_block_guard
  import flp_pkg::*;
#(
  parameter  int NUM_BLK = 64,
  localparam int IDX_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_reset,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_blk,
  input  logic             wp_n,
  input  logic             op_start,
  input  logic [IDX_W-1:0] op_blk,
  input  logic [1:0]       vpp_lvl,
  input  logic             op_done,
  input  logic             clr_status,
  input  logic [IDX_W-1:0] rd_blk,
  output logic             grant,
  output logic             deny,
  output logic             prot_err,
  output logic             op_run,
  output logic             rd_locked,
  output logic             rd_lockdn
);
  logic                rst_meta;
  logic                rst_s_n;
  logic [NUM_BLK-1:0]  locked_vec;
  logic [NUM_BLK-1:0]  lockdn_vec;
  logic                tgt_locked;
  logic                rd_lk_nxt;
  logic                rd_ld_nxt;
  lk_op_e              op_dec;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s_n  <= rst_meta;
    end
  end

  assign op_dec = lk_op_e'(cmd_op);

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_cell
    logic hit;
    assign hit = cmd_valid & (cmd_blk == IDX_W'(b));
    flp_lock_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_s_n),
      .dev_reset (dev_reset),
      .cmd_hit   (hit),
      .cmd_op    (op_dec),
      .wp_n      (wp_n),
      .locked    (locked_vec[b]),
      .lockdn    (lockdn_vec[b])
    );
  end

  always_comb begin
    tgt_locked = 1'b1;
    rd_lk_nxt  = 1'b1;
    rd_ld_nxt  = 1'b0;
    if (int'(op_blk) < NUM_BLK) tgt_locked = locked_vec[op_blk];
    if (int'(rd_blk) < NUM_BLK) begin
      rd_lk_nxt = locked_vec[rd_blk];
      rd_ld_nxt = lockdn_vec[rd_blk];
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rd_locked <= 1'b1;
      rd_lockdn <= 1'b0;
    end else begin
      rd_locked <= rd_lk_nxt;
      rd_lockdn <= rd_ld_nxt;
    end
  end

  flp_req_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .dev_reset  (dev_reset),
    .op_start   (op_start),
    .tgt_locked (tgt_locked),
    .vpp_lvl    (vpp_lvl),
    .op_done    (op_done),
    .clr_status (clr_status),
    .grant      (grant),
    .deny       (deny),
    .prot_err   (prot_err),
    .op_run     (op_run)
  );
endmodule

// File: rtl/flp_block_guard_chk.sv
module flp_block_guard_chk #(
  parameter int NUM_BLK = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dev_reset,
  input logic               wp_n,
  input logic               op_start,
  input logic [1:0]         vpp_lvl,
  input logic               op_done,
  input logic               clr_status,
  input logic               grant,
  input logic               deny,
  input logic               prot_err,
  input logic               op_run,
  input logic [NUM_BLK-1:0] locked_vec,
  input logic [NUM_BLK-1:0] lockdn_vec
);
  p_reset_relock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |=> ((&locked_vec) && (lockdn_vec == '0) && !prot_err && !op_run));

  p_lockdn_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_reset |=> (($past(lockdn_vec) & ~lockdn_vec) == '0));

  p_frozen_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && !dev_reset) |=> (((locked_vec ^ $past(locked_vec)) & $past(lockdn_vec)) == '0));

  p_low_vpp_deny_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && vpp_lvl == 2'b00 && !dev_reset) |=> (deny && !grant));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_err && !clr_status && !dev_reset) |=> prot_err);

  p_run_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_run && !op_done && !dev_reset) |=> op_run);

  p_busy_noerr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_run && !clr_status && !dev_reset) |=> (deny && prot_err == $past(prot_err)));

  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !dev_reset) |=> (grant != deny));
endmodule

bind flp_block_guard flp_block_guard_chk #(.NUM_BLK(NUM_BLK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_s_n),
  .dev_reset  (dev_reset),
  .wp_n       (wp_n),
  .op_start   (op_start),
  .vpp_lvl    (vpp_lvl),
  .op_done    (op_done),
  .clr_status (clr_status),
  .grant      (grant),
  .deny       (deny),
  .prot_err   (prot_err),
  .op_run     (op_run),
  .locked_vec (locked_vec),
  .lockdn_vec (lockdn_vec)
);

// File: tb/flp_block_guard_tb.sv
module flp_block_guard_tb;
  localparam int NB = 64;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n, dev_reset, cmd_valid, wp_n, op_start, op_done, clr_status;
  logic [1:0] cmd_op, vpp_lvl;
  logic [IW-1:0] cmd_blk, op_blk, rd_blk;
  logic grant, deny, prot_err, op_run, rd_locked, rd_lockdn;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  bit m_lk [NB];
  bit m_ld [NB];
  bit m_err, m_run;

  always #10 clk = ~clk;

  flp_block_guard #(.NUM_BLK(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_reset(dev_reset), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_blk(cmd_blk), .wp_n(wp_n), .op_start(op_start),
    .op_blk(op_blk), .vpp_lvl(vpp_lvl), .op_done(op_done),
    .clr_status(clr_status), .rd_blk(rd_blk), .grant(grant), .deny(deny),
    .prot_err(prot_err), .op_run(op_run), .rd_locked(rd_locked),
    .rd_lockdn(rd_lockdn)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NB; i++) begin m_lk[i] = 1; m_ld[i] = 0; end
    m_err = 0; m_run = 0;
  endtask

  task automatic model_cmd(logic [1:0] op, int b);
    if (!(m_ld[b] && !wp_n)) begin
      case (op)
        2'b01: m_lk[b] = 1;
        2'b10: m_lk[b] = 0;
        2'b11: begin m_lk[b] = 1; m_ld[b] = 1; end
        default: ;
      endcase
    end
  endtask

  task automatic do_cmd(logic [1:0] op, int b);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_blk = IW'(b);
    model_cmd(op, b);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic rd_chk(int b, string req);
    @(negedge clk);
    rd_blk = IW'(b);
    @(negedge clk);
    check({req, " locked"}, 32'(rd_locked), 32'(m_lk[b]));
    check({req, " lockdn"}, 32'(rd_lockdn), 32'(m_ld[b]));
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < NB; i++) rd_chk(i, req);
  endtask

  // request evaluated against the bench model, sampled one cycle later
  task automatic req_eval(int b, logic [1:0] v, string req);
    bit g, e;
    g = !m_run && (v != 0) && !m_lk[b];
    e = !m_run && (v != 0) && m_lk[b];
    op_start = 1; op_blk = IW'(b); vpp_lvl = v;
    if (e) m_err = 1;
    if (g) m_run = 1;
    @(negedge clk);
    op_start = 0;
    check({req, " grant"}, 32'(grant), 32'(g));
    check({req, " deny"}, 32'(deny), 32'(!g));
    check({req, " prot_err"}, 32'(prot_err), 32'(m_err));
    check({req, " op_run"}, 32'(op_run), 32'(m_run));
  endtask

  task automatic do_req(int b, logic [1:0] v, string req);
    @(negedge clk);
    req_eval(b, v, req);
  endtask

  task automatic finish_op(string req);
    @(negedge clk); op_done = 1;
    @(negedge clk); op_done = 0; m_run = 0;
    check({req, " run end"}, 32'(op_run), 0);
  endtask

  task automatic clear_err(string req);
    @(negedge clk); clr_status = 1;
    @(negedge clk); clr_status = 0; m_err = 0;
    check({req, " err clear"}, 32'(prot_err), 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; dev_reset = 0; cmd_valid = 0; cmd_op = 0; cmd_blk = 0;
    wp_n = 1; op_start = 0; op_blk = 0; vpp_lvl = 1; op_done = 0;
    clr_status = 0; rd_blk = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: power-up state
    check("R1 grant", 32'(grant), 0);
    check("R1 deny", 32'(deny), 0);
    check("R1 prot_err", 32'(prot_err), 0);
    check("R1 op_run", 32'(op_run), 0);
    sweep("R1 powerup R10");

    // R2: unlock even blocks, then lock one back
    for (int i = 0; i < NB; i += 2) do_cmd(2'b10, i);
    do_cmd(2'b00, 6);
    do_cmd(2'b01, 10);
    sweep("R2 pattern R10");

    // R6 / R8: request to every block
    for (int i = 0; i < NB; i++) begin
      do_req(i, 2'b01, m_lk[i] ? "R8 locked" : "R6 unlocked");
      if (m_run) finish_op("R6");
      if (m_err) clear_err("R8");
    end

    // R2: zero added latency, request in the cycle right after the command
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'b10; cmd_blk = IW'(5); model_cmd(2'b10, 5);
    @(negedge clk);
    cmd_valid = 0;
    req_eval(5, 2'b01, "R2 unlock then request");
    finish_op("R2");
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'b01; cmd_blk = IW'(5); model_cmd(2'b01, 5);
    @(negedge clk);
    cmd_valid = 0;
    req_eval(5, 2'b01, "R2 lock then request");
    clear_err("R2");

    // R7: low supply code refused on unlocked and locked blocks
    do_req(0, 2'b00, "R7 unlocked low vpp");
    do_req(1, 2'b00, "R7 locked low vpp");

    // R3: lock-down of a locked and an unlocked block
    do_cmd(2'b11, 3);
    do_cmd(2'b11, 4);
    rd_chk(3, "R3 lockdown");
    rd_chk(4, "R3 lockdown");

    // R4: frozen while write-protect is low
    wp_n = 0;
    do_cmd(2'b10, 3);
    do_cmd(2'b10, 4);
    rd_chk(3, "R4 frozen unlock");
    rd_chk(4, "R4 frozen unlock");
    do_req(4, 2'b01, "R4 frozen request");
    clear_err("R4");

    // R5: write-protect high lets the lock bit move, lock-down stays
    wp_n = 1;
    do_cmd(2'b10, 4);
    rd_chk(4, "R5 unlock locked-down");
    wp_n = 0;
    do_cmd(2'b01, 4);
    rd_chk(4, "R4 frozen lock");

    // R9: grant, then drop supply code and request again while running
    do_req(4, 2'b10, "R9 grant");
    @(negedge clk); vpp_lvl = 2'b00;
    repeat (3) @(negedge clk);
    check("R9 run held", 32'(op_run), 1);
    do_req(2, 2'b01, "R9 busy");
    do_req(7, 2'b01, "R9 busy locked");
    finish_op("R9");

    // R8: error set and clear in the same cycle keeps the flag
    @(negedge clk);
    op_start = 1; op_blk = IW'(1); vpp_lvl = 2'b01; clr_status = 1;
    @(negedge clk);
    op_start = 0; clr_status = 0; m_err = 1;
    check("R8 set wins prot_err", 32'(prot_err), 1);
    check("R11 deny only", 32'(deny), 1);
    check("R11 no grant", 32'(grant), 0);
    clear_err("R8");

    // R1: flash reset re-locks everything and clears lock-down
    do_req(1, 2'b01, "R8 before reset");
    @(negedge clk); dev_reset = 1;
    @(negedge clk); dev_reset = 0; model_reset();
    check("R1 reset prot_err", 32'(prot_err), 0);
    sweep("R1 dev_reset R10");

    // R3: after reset the former locked-down block unlocks with wp_n low
    do_cmd(2'b10, 3);
    rd_chk(3, "R3 lockdn cleared by reset");
    do_req(3, 2'b01, "R3 grant after reset");
    finish_op("R3");

    done = 1;
    summary();
    $finish;
  end
endmodule